// File: doc/BRIEF.md
# PS/2 Host Register Interface

This block is the software-visible front end of one PS/2 keyboard or mouse port. A simple 32-bit bus slave reaches a 4 KB window of word registers: control, status, data, clock divisor and interrupt status. On the other side sits a byte-level device link. Its receive side is a pending flag plus the byte on offer, which the block pops on request. Its transmit side is a byte that the block presents with a one-cycle strobe. The serial clock/data signalling and the real transmit timing belong to the device model behind the link.

A bus access lasts exactly one cycle: `bus_sel` qualifies it and `bus_wr` selects its direction. Read data is combinational in the access cycle. Register state changes on the clock edge that ends the access. A data-register read consumes a pending byte in that same cycle and remembers it. The receive-parity status bit is derived from the remembered byte. A single level interrupt combines "byte pending" gated by a control enable with a second control bit that forces the line high. The top eight words of the window return a fixed identification sequence. Any access the map does not define raises a one-cycle `bad_access` flag and changes nothing.

Top module: `ps2_host_regs`

## Requirements
- R1: After a synchronous active-low reset the control, divisor and remembered-byte registers are zero. `irq`, `dev_pop`, `dev_tx_strobe` and `bad_access` are low.
- R2: A write to offset 0x000 stores `bus_wdata[7:0]` as the control value. A read of 0x000 returns it, with bits 31:8 zero.
- R3: A write to offset 0x00C stores `bus_wdata[7:0]` as the clock divisor. A read of 0x00C returns it, with bits 31:8 zero.
- R4: A read of offset 0x004 returns the status word. Bit 6 is 1 (transmitter empty). Bits 5 and 3 are 0 (never busy). Bit 4 equals `dev_pending`. Bit 2 is the XOR of the eight bits of the remembered byte. Bit 1 equals `line_clk` and bit 0 equals `line_dat`. All other bits are 0.
- R5: In a read of offset 0x008 with `dev_pending` high, `dev_pop` is high in that cycle. The read returns `dev_rx_byte`, and that byte becomes the remembered byte. With nothing pending the read returns the remembered byte and `dev_pop` stays low.
- R6: A write to offset 0x008 makes `dev_tx_strobe` high in the next cycle, for one cycle per write. In that cycle `dev_tx_byte` equals the written `bus_wdata[7:0]`.
- R7: `irq` equals (`dev_pending` AND control bit 4) OR control bit 3. It follows a change of `dev_pending` in the same cycle and a control write from the next cycle.
- R8: A read of offset 0x010 returns `dev_pending` in bit 0, 1 in bit 1, and 0 elsewhere.
- R9: Reads of offsets 0xFE0, 0xFE4, … 0xFFC return 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R10: A read of any other offset returns 0. A write to any offset other than 0x000, 0x008 and 0x00C changes no state. Each such access raises `bad_access` for its cycle, and defined accesses never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the 4 KB window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| bad_access | output | 1 | Undefined access this cycle |
| dev_pending | input | 1 | Device holds a received byte |
| dev_rx_byte | input | 8 | Byte on offer from the device |
| dev_pop | output | 1 | Consume the offered byte this cycle |
| dev_tx_byte | output | 8 | Byte sent to the device |
| dev_tx_strobe | output | 1 | `dev_tx_byte` is new this cycle |
| line_clk | input | 1 | Sampled PS/2 clock line level |
| line_dat | input | 1 | Sampled PS/2 data line level |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in one cycle. The first is a data read that pops the last pending byte while the receive interrupt is enabled. `irq` must drop on the cycle that follows, and the same read must still return the popped byte. The second is a control write that enables the receive interrupt in the very cycle a byte first becomes pending. `irq` must rise with the pending flag only once the new control value is in place. The bench provokes both by changing the device queue and the bus access together. A behavioural model judges `irq`, `dev_pop` and read data on every clock.

// File: rtl/ps2r_pkg.sv
// Package: ps2r_pkg
// Shared register indices, bit positions, access-decode type and the
// identification byte lookup for the PS/2 host register interface.
// Assumes a 32-bit word-indexed register map inside a 4 KB window.
package ps2r_pkg;

    // Word indices within the window (address bits above 1:0)
    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_DATA = 2;
    localparam int IDX_DIV  = 3;
    localparam int IDX_ISR  = 4;

    // Status word bit positions
    localparam int ST_TX_EMPTY = 6;
    localparam int ST_TX_BUSY  = 5;
    localparam int ST_RX_FULL  = 4;
    localparam int ST_RX_BUSY  = 3;
    localparam int ST_RX_PAR   = 2;
    localparam int ST_LINE_CLK = 1;
    localparam int ST_LINE_DAT = 0;

    // Control bit positions used by the interrupt logic
    localparam int CTRL_RX_IE = 4;
    localparam int CTRL_FORCE = 3;

    // Interrupt status register bit positions
    localparam int ISR_PEND  = 0;
    localparam int ISR_CONST = 1;

    // Decoded action of one bus access
    typedef struct packed {
        logic rd_ctrl;
        logic rd_stat;
        logic rd_data;
        logic rd_div;
        logic rd_isr;
        logic rd_id;
        logic wr_ctrl;
        logic wr_data;
        logic wr_div;
        logic bad;
    } acc_t;

    // Identification byte for word k of the top eight words
    function automatic logic [7:0] id_byte(input logic [2:0] k);
        logic [7:0] v;
        case (k)
            3'd0: v = 8'h50;
            3'd1: v = 8'h10;
            3'd2: v = 8'h04;
            3'd3: v = 8'h00;
            3'd4: v = 8'h0D;
            3'd5: v = 8'hF0;
            3'd6: v = 8'h05;
            default: v = 8'hB1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ps2r_decode.sv
// Module: ps2r_decode
// Turns one bus access into a single decoded action. The top eight words
// of the window are the identification block (read only). Every access
// the map does not define becomes a "bad" action.
// Assumes bus_sel qualifies a single-cycle access; address bits 1:0 are ignored.
module ps2r_decode
    import ps2r_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_t              acc
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             in_id_win;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign in_id_win = &bus_addr[ADDR_W-1:5];

    // Purpose: classify the current access into exactly one action
    always_comb begin
        acc = '0;
        if (bus_sel) begin
            if (!bus_wr) begin
                if (in_id_win) begin
                    acc.rd_id = 1'b1;
                end else begin
                    case (idx)
                        IDX_W'(IDX_CTRL): acc.rd_ctrl = 1'b1;
                        IDX_W'(IDX_STAT): acc.rd_stat = 1'b1;
                        IDX_W'(IDX_DATA): acc.rd_data = 1'b1;
                        IDX_W'(IDX_DIV):  acc.rd_div  = 1'b1;
                        IDX_W'(IDX_ISR):  acc.rd_isr  = 1'b1;
                        default:          acc.bad     = 1'b1;
                    endcase
                end
            end else begin
                case (idx)
                    IDX_W'(IDX_CTRL): acc.wr_ctrl = 1'b1;
                    IDX_W'(IDX_DATA): acc.wr_data = 1'b1;
                    IDX_W'(IDX_DIV):  acc.wr_div  = 1'b1;
                    default:          acc.bad     = 1'b1;
                endcase
            end
        end
    end

    // R10: every access resolves to exactly one action, idle to none
    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> ($countones(acc) == 1));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (acc == '0));

endmodule

// File: rtl/ps2r_cfg_reg.sv
// Module: ps2r_cfg_reg
// A plain read/write configuration register that loads the low W bits of
// the bus write data on its write enable. Used for control and divisor.
// Assumes the write enable is a single-cycle decoded pulse.
module ps2r_cfg_reg #(
    parameter int W      = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      q
);
    // Purpose: hold the configuration value, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata[W-1:0];
    end

    // R2 and R3: a write stores its value, nothing else moves the register
    p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata[W-1:0])));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/ps2r_rx_path.sv
// Module: ps2r_rx_path
// Receive side: pops the device byte on a data read while one is pending,
// remembers the last popped byte and derives its parity.
// Assumes the device keeps dev_rx_byte valid while dev_pending is high.
module ps2r_rx_path #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_data,
    input  logic              dev_pending,
    input  logic [BYTE_W-1:0] dev_rx_byte,
    output logic              dev_pop,
    output logic [BYTE_W-1:0] rx_view,
    output logic              rx_parity
);
    logic [BYTE_W-1:0] last_q;

    // Purpose: request a byte only when one is on offer
    assign dev_pop = rd_data & dev_pending;

    // Purpose: the read returns the fresh byte when popping, else the old one
    assign rx_view = dev_pending ? dev_rx_byte : last_q;

    // Purpose: odd-ones flag of the remembered byte
    assign rx_parity = ^last_q;

    // Purpose: remember the byte taken on a pop
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= '0;
        else if (dev_pop) last_q <= dev_rx_byte;
    end

    // R5: popping latches the offered byte; otherwise it is kept
    p_pop_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pop |=> (last_q == $past(dev_rx_byte)));
    p_keep_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_pop |=> $stable(last_q));
    p_pop_needs_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pop |-> dev_pending);

endmodule

// File: rtl/ps2r_tx_path.sv
// Module: ps2r_tx_path
// Transmit side: a data write is registered and offered to the device with
// a one-cycle strobe on the following cycle.
// Assumes the device accepts one byte per strobe without backpressure.
module ps2r_tx_path #(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    output logic [BYTE_W-1:0] dev_tx_byte,
    output logic              dev_tx_strobe
);
    // Purpose: register the outgoing byte and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_tx_byte   <= '0;
            dev_tx_strobe <= 1'b0;
        end else begin
            dev_tx_strobe <= wr_data;
            if (wr_data) dev_tx_byte <= wdata[BYTE_W-1:0];
        end
    end

    // R6: each write yields one strobe carrying its byte, nothing else does
    p_strobe_carries_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (dev_tx_strobe && dev_tx_byte == $past(wdata[BYTE_W-1:0])));
    p_no_stray_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> !dev_tx_strobe);

endmodule

// File: rtl/ps2_host_regs.sv
// Module: ps2_host_regs
// Register front end of one PS/2 port: decodes single-cycle bus accesses,
// holds control and divisor, builds status and interrupt status, serves the
// identification block, and drives the device pop/transmit link and irq.
// Assumes single-cycle accesses with combinational read data.
module ps2_host_regs
    import ps2r_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bad_access,
    input  logic              dev_pending,
    input  logic [BYTE_W-1:0] dev_rx_byte,
    output logic              dev_pop,
    output logic [BYTE_W-1:0] dev_tx_byte,
    output logic              dev_tx_strobe,
    input  logic              line_clk,
    input  logic              line_dat,
    output logic              irq
);
    acc_t              acc;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [BYTE_W-1:0] rx_view;
    logic              rx_parity;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] isr_word;

    ps2r_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    ps2r_cfg_reg #(.W(CTRL_W), .DATA_W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (acc.wr_ctrl),
        .wdata (bus_wdata),
        .q     (ctrl_q)
    );

    ps2r_cfg_reg #(.W(DIV_W), .DATA_W(DATA_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (acc.wr_div),
        .wdata (bus_wdata),
        .q     (div_q)
    );

    ps2r_rx_path #(.BYTE_W(BYTE_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_data     (acc.rd_data),
        .dev_pending (dev_pending),
        .dev_rx_byte (dev_rx_byte),
        .dev_pop     (dev_pop),
        .rx_view     (rx_view),
        .rx_parity   (rx_parity)
    );

    ps2r_tx_path #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_data       (acc.wr_data),
        .wdata         (bus_wdata),
        .dev_tx_byte   (dev_tx_byte),
        .dev_tx_strobe (dev_tx_strobe)
    );

    // Purpose: assemble the status word from live inputs and rx parity
    always_comb begin
        stat_word              = '0;
        stat_word[ST_TX_EMPTY] = 1'b1;
        stat_word[ST_TX_BUSY]  = 1'b0;
        stat_word[ST_RX_FULL]  = dev_pending;
        stat_word[ST_RX_BUSY]  = 1'b0;
        stat_word[ST_RX_PAR]   = rx_parity;
        stat_word[ST_LINE_CLK] = line_clk;
        stat_word[ST_LINE_DAT] = line_dat;
    end

    // Purpose: assemble the interrupt status word
    always_comb begin
        isr_word            = '0;
        isr_word[ISR_PEND]  = dev_pending;
        isr_word[ISR_CONST] = 1'b1;
    end

    // Purpose: select read data for the decoded read, zero otherwise
    always_comb begin
        bus_rdata = '0;
        if (acc.rd_ctrl) bus_rdata = DATA_W'(ctrl_q);
        if (acc.rd_stat) bus_rdata = stat_word;
        if (acc.rd_data) bus_rdata = DATA_W'(rx_view);
        if (acc.rd_div)  bus_rdata = DATA_W'(div_q);
        if (acc.rd_isr)  bus_rdata = isr_word;
        if (acc.rd_id)   bus_rdata = DATA_W'(id_byte(bus_addr[4:2]));
    end

    // Purpose: flag undefined accesses for their cycle
    assign bad_access = acc.bad;

    // Purpose: level interrupt from gated pending and the force bit
    assign irq = (dev_pending & ctrl_q[CTRL_RX_IE]) | ctrl_q[CTRL_FORCE];

    // R10: an undefined access leaves configuration alone and pops nothing
    p_bad_keeps_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> ($stable(ctrl_q) && $stable(div_q)));
    p_bad_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> (!dev_pop && bus_rdata == '0));
    // R7: with the force bit clear and nothing pending the line is low
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_pending && !ctrl_q[CTRL_FORCE]) |-> !irq);

endmodule

// File: tb/sim_ps2_host_regs.sv
`timescale 1ns/1ps
module sim_ps2_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bad_access;
    logic        dev_pending = 1'b0;
    logic [7:0]  dev_rx_byte = '0;
    logic        dev_pop;
    logic [7:0]  dev_tx_byte;
    logic        dev_tx_strobe;
    logic        line_clk = 1'b0;
    logic        line_dat = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural model state
    logic [7:0] m_ctrl = '0;
    logic [7:0] m_div  = '0;
    logic [7:0] m_last = '0;
    logic [7:0] m_txb  = '0;
    bit         m_stb  = 0;
    logic [7:0] devq[$];
    logic [7:0] id_tab[8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always #2 clk = ~clk;

    ps2_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bad_access(bad_access), .dev_pending(dev_pending),
        .dev_rx_byte(dev_rx_byte), .dev_pop(dev_pop), .dev_tx_byte(dev_tx_byte),
        .dev_tx_strobe(dev_tx_strobe), .line_clk(line_clk), .line_dat(line_dat),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, compare before posedge, advance model
    task automatic cyc(input bit s, input bit w, input logic [11:0] a, input logic [31:0] d);
        bit          pend;
        bit          in_win;
        int          idx;
        bit          exp_bad;
        bit          exp_pop;
        logic [31:0] exp_rd;
        string       rtag;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        pend = (devq.size() != 0);
        dev_pending = pend;
        dev_rx_byte = pend ? devq[0] : 8'h00;
        #1;
        idx = int'(a[11:2]);
        in_win = (a[11:5] == 7'h7F);
        exp_bad = 0; exp_pop = 0; exp_rd = '0; rtag = "R10";
        if (s && !w) begin
            if (in_win) begin exp_rd = {24'h0, id_tab[a[4:2]]}; rtag = "R9"; end
            else case (idx)
                0: begin exp_rd = {24'h0, m_ctrl}; rtag = "R2"; end
                1: begin exp_rd = {25'h0, 1'b1, 1'b0, pend, 1'b0, ^m_last, line_clk, line_dat}; rtag = "R4"; end
                2: begin exp_rd = {24'h0, pend ? devq[0] : m_last}; exp_pop = pend; rtag = "R5"; end
                3: begin exp_rd = {24'h0, m_div}; rtag = "R3"; end
                4: begin exp_rd = {30'h0, 1'b1, pend}; rtag = "R8"; end
                default: exp_bad = 1;
            endcase
            chk(rtag, bus_rdata, exp_rd);
        end else if (s && w) begin
            if (!(idx == 0 || idx == 2 || idx == 3)) exp_bad = 1;
        end
        chk("R10 bad_access", 32'(bad_access), 32'(exp_bad));
        chk("R5 dev_pop", 32'(dev_pop), 32'(exp_pop));
        chk("R7 irq", 32'(irq), 32'((pend & m_ctrl[4]) | m_ctrl[3]));
        chk("R6 strobe", 32'(dev_tx_strobe), 32'(m_stb));
        chk("R6 tx_byte", 32'(dev_tx_byte), 32'(m_txb));
        @(posedge clk);
        m_stb = 0;
        if (s && w && idx == 0) m_ctrl = d[7:0];
        if (s && w && idx == 3) m_div = d[7:0];
        if (s && w && idx == 2) begin m_stb = 1; m_txb = d[7:0]; end
        if (exp_pop) begin m_last = devq[0]; void'(devq.pop_front()); end
    endtask

    task automatic rd(input logic [11:0] a); cyc(1, 0, a, '0); endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, 1, a, d); endtask
    task automatic idle(); cyc(0, 0, '0, '0); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in reset, registers read zero after it
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 pop", 32'(dev_pop), 0);
        chk("R1 strobe", 32'(dev_tx_strobe), 0);
        chk("R1 bad", 32'(bad_access), 0);
        rst_n = 1'b1;
        rd(12'h000); rd(12'h00C); rd(12'h008); rd(12'h004); rd(12'h010);
        // R2, R3 store and read back low byte
        wr(12'h000, 32'hA5A5_A5E7); rd(12'h000);
        wr(12'h00C, 32'h1234_5678); rd(12'h00C);
        wr(12'h000, 32'h0000_0000); rd(12'h000);
        // R4 line levels in status
        line_clk = 1'b1; rd(12'h004);
        line_dat = 1'b1; line_clk = 1'b0; rd(12'h004);
        // R5 pops with several parities
        devq.push_back(8'h01); devq.push_back(8'hFF); devq.push_back(8'h7E); devq.push_back(8'h80);
        rd(12'h004); rd(12'h010);
        for (int k = 0; k < 4; k++) begin rd(12'h008); rd(12'h004); end
        rd(12'h008); rd(12'h008); rd(12'h010);
        // R6 back-to-back transmits
        wr(12'h008, 32'hFFFF_F1AB); wr(12'h008, 32'h0000_02CD); idle(); idle();
        // R7 force bit and gated pending
        wr(12'h000, 32'h08); idle(); wr(12'h000, 32'h00); idle();
        // same cycle: control enables rx interrupt as a byte arrives
        devq.push_back(8'h3C); wr(12'h000, 32'h10); idle(); rd(12'h004);
        // same cycle: popping the last byte with the interrupt enabled
        rd(12'h008); idle(); rd(12'h004);
        devq.push_back(8'h55); idle(); wr(12'h000, 32'h00); idle(); rd(12'h008);
        // R9 identification block
        for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(k * 4));
        rd(12'hFE3);
        // R10 undefined accesses
        wr(12'h000, 32'h5A);
        rd(12'h014); rd(12'h800); rd(12'hFDC);
        wr(12'h004, 32'hFF); wr(12'h010, 32'hFF); wr(12'hFE0, 32'hFF); wr(12'h100, 32'hFF);
        devq.push_back(8'h99); wr(12'h014, 32'hFF); rd(12'h010);
        rd(12'h000); rd(12'h00C); rd(12'h008); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule